// File: doc/BRIEF.md
# Set/Clear/Toggle Control Register Bank

This block holds the control registers of a peripheral and exposes them on a simple synchronous bus (address, write strobe, write data, read strobe, read data). Every 32-bit control register occupies a 16-byte slot. The lowest word of a slot replaces the register. The other three words of the slot change only selected bits: they OR the write data in, remove the bits that are 1 in the write data, or flip those bits. Software can therefore change one field without a read-modify-write sequence. After the control registers come read-only status slots whose contents the peripheral core supplies. All other slots read as zero and ignore writes.

Control register 0 carries a soft-reset handshake. Setting its top bit asks the core to reset. A fixed number of cycles later, and once the core reports that its reset is done, the block sets the clock-gate bit below it. Software polls that bit to learn that the reset has completed. It then clears the soft-reset bit and, to run the unit again, the clock-gate bit. The full register contents are driven continuously to the core.

Top module: `sct_reg_bank`

## Requirements
- R1: After the reset input is released, every control register holds 0 and the read data output is 0.
- R2: Control register k sits at byte offset 16*k. Address bits [3:2] select the access kind: 00 replaces the whole register with the write data. Address bits [1:0] are ignored.
- R3: A write with address bits [3:2] = 01 ORs the write data into the addressed control register.
- R4: A write with address bits [3:2] = 10 clears every register bit for which the write data bit is 1 and keeps the rest.
- R5: A write with address bits [3:2] = 11 inverts every register bit for which the write data bit is 1 and keeps the rest.
- R6: A read strobe returns the addressed register's value on the read data output one cycle later, whatever the access kind in bits [3:2]. A write in the same cycle is not yet visible in that read. Without a read strobe the read data output holds its value.
- R7: Slots NUM_CTRL to NUM_CTRL+NUM_STAT-1 read the status inputs in order. Writes of any kind to them leave every control register unchanged. Slots beyond them read 0 and ignore writes.
- R8: When bit 31 (soft reset) of control register 0 becomes 1, bit 30 (clock gate) of that register becomes 1 exactly RST_CYCLES clock edges after the edge that set bit 31, provided the core's reset-done input is high. No other register bit changes.
- R9: If the reset-done input is low when the count has elapsed, the clock-gate bit is set on the first edge on which reset-done is high.
- R10: Clearing bit 31 makes it read 0 while bit 30 stays 1 until software clears it. Setting bit 31 again restarts the full count.
- R11: If the handshake sets the clock-gate bit on the same edge as a bus write to control register 0, the other bits take the result of the write and the clock-gate bit ends at 1.
- R12: The control register output presents every control register's current value in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address of the access |
| wr_en_i | input | 1 | Write strobe for one cycle |
| wdata_i | input | 32 | Write data or bit mask |
| rd_en_i | input | 1 | Read strobe for one cycle |
| rdata_o | output | 32 | Read data, valid the cycle after the strobe |
| ctrl_o | output | NUM_CTRL x 32 | Current contents of all control registers |
| stat_i | input | NUM_STAT x 32 | Status words from the core |
| core_rst_done_i | input | 1 | Core reports that its internal reset is finished |

## Verification
The handshake's completion can fall on the same edge as a software write to control register 0. The bench provokes this by starting a soft reset and then timing a write so that it lands exactly on the completion edge. It does this once with a replacing write that leaves the clock-gate bit at 0, and once with a clear-alias write aimed at that bit. It then judges that the clock-gate bit ends at 1 and that every other bit matches the write. A read strobe and a write to the same register in one cycle are also driven together, and the read must return the older value while the register takes the new one.

// File: rtl/sct_bank_pkg.sv
package sct_bank_pkg;

    localparam int REG_W    = 32;
    localparam int SRST_BIT = 31;
    localparam int GATE_BIT = 30;

    // access kind carried in address bits [3:2]
    typedef enum logic [1:0] {
        OP_WRITE  = 2'd0,
        OP_SET    = 2'd1,
        OP_CLEAR  = 2'd2,
        OP_TOGGLE = 2'd3
    } slot_op_e;

    function automatic logic [REG_W-1:0] apply_op(slot_op_e op,
                                                  logic [REG_W-1:0] cur,
                                                  logic [REG_W-1:0] wd);
        logic [REG_W-1:0] res;
        case (op)
            OP_WRITE:  res = wd;
            OP_SET:    res = cur | wd;
            OP_CLEAR:  res = cur & ~wd;
            default:   res = cur ^ wd;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/sct_addr_decode.sv
module sct_addr_decode
    import sct_bank_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int NUM_CTRL = 4,
    parameter int NUM_STAT = 2
) (
    input  logic [ADDR_W-1:0]   addr_i,
    output slot_op_e            op_o,
    output logic [NUM_CTRL-1:0] ctrl_hit_o,
    output logic [NUM_STAT-1:0] stat_hit_o
);

    localparam int SLOT_W = ADDR_W - 4;

    logic [SLOT_W-1:0] slot;
    logic              unused_lsb;

    assign slot       = addr_i[ADDR_W-1:4];
    assign op_o       = slot_op_e'(addr_i[3:2]);
    assign unused_lsb = ^addr_i[1:0];

    always_comb begin
        for (int i = 0; i < NUM_CTRL; i++) begin
            ctrl_hit_o[i] = (slot == SLOT_W'(i));
        end
        for (int j = 0; j < NUM_STAT; j++) begin
            stat_hit_o[j] = (slot == SLOT_W'(NUM_CTRL + j));
        end
    end

endmodule

// File: rtl/sct_ctrl_reg.sv
module sct_ctrl_reg
    import sct_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  slot_op_e         op_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic [REG_W-1:0] hw_set_i,
    output logic [REG_W-1:0] q_o
);

    typedef struct packed {
        logic [REG_W-1:0] val;
    } reg_st_t;

    reg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            st_d.val = apply_op(op_i, st_q.val, wdata_i);
        end
        // hardware-set bits are applied after the bus result
        st_d.val = st_d.val | hw_set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.val;

    // R3
    set_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && op_i == OP_SET) |=> (q_o == ($past(q_o) | $past(wdata_i) | $past(hw_set_i))));

    // R4
    clear_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && op_i == OP_CLEAR && hw_set_i == '0) |=> ((q_o & $past(wdata_i)) == '0));

    // R5
    toggle_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && op_i == OP_TOGGLE && hw_set_i == '0) |=> (q_o == ($past(q_o) ^ $past(wdata_i))));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_i && hw_set_i == '0) |=> $stable(q_o));

endmodule

// File: rtl/sct_reset_seq.sv
module sct_reset_seq #(
    parameter int RST_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic srst_i,
    input  logic core_done_i,
    output logic gate_set_o
);

    localparam int CNT_W = $clog2(RST_CYCLES + 1);
    localparam int LAST  = RST_CYCLES - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        gate_set_o = 1'b0;
        if (!srst_i) begin
            st_d.cnt  = '0;
            st_d.done = 1'b0;
        end else if (!st_q.done) begin
            if (st_q.cnt == CNT_W'(LAST)) begin
                if (core_done_i) begin
                    gate_set_o = 1'b1;
                    st_d.done  = 1'b1;
                end
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R8
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_set_o |=> !gate_set_o);

    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(LAST));

    // R10
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !srst_i |=> (st_q.cnt == '0 && !st_q.done));

endmodule

// File: rtl/sct_reg_bank.sv
module sct_reg_bank
    import sct_bank_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int NUM_CTRL   = 4,
    parameter int NUM_STAT   = 2,
    parameter int RST_CYCLES = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic                           wr_en_i,
    input  logic [REG_W-1:0]               wdata_i,
    input  logic                           rd_en_i,
    output logic [REG_W-1:0]               rdata_o,
    output logic [NUM_CTRL-1:0][REG_W-1:0] ctrl_o,
    input  logic [NUM_STAT-1:0][REG_W-1:0] stat_i,
    input  logic                           core_rst_done_i
);

    slot_op_e                      op;
    logic [NUM_CTRL-1:0]           ctrl_hit;
    logic [NUM_STAT-1:0]           stat_hit;
    logic [NUM_CTRL-1:0][REG_W-1:0] ctrl_q;
    logic                          gate_set;

    sct_addr_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_CTRL (NUM_CTRL),
        .NUM_STAT (NUM_STAT)
    ) i_decode (
        .addr_i     (addr_i),
        .op_o       (op),
        .ctrl_hit_o (ctrl_hit),
        .stat_hit_o (stat_hit)
    );

    for (genvar g = 0; g < NUM_CTRL; g++) begin : g_ctrl
        logic [REG_W-1:0] hw_set;
        if (g == 0) begin : g_head
            assign hw_set = gate_set ? (REG_W'(1) << GATE_BIT) : '0;
        end else begin : g_rest
            assign hw_set = '0;
        end

        sct_ctrl_reg i_reg (
            .clk      (clk),
            .rst_n    (rst_n),
            .we_i     (wr_en_i & ctrl_hit[g]),
            .op_i     (op),
            .wdata_i  (wdata_i),
            .hw_set_i (hw_set),
            .q_o      (ctrl_q[g])
        );
    end

    sct_reset_seq #(
        .RST_CYCLES (RST_CYCLES)
    ) i_rst_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .srst_i      (ctrl_q[0][SRST_BIT]),
        .core_done_i (core_rst_done_i),
        .gate_set_o  (gate_set)
    );

    typedef struct packed {
        logic [REG_W-1:0] data;
    } rd_st_t;

    rd_st_t rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        if (rd_en_i) begin
            rd_d.data = '0;
            for (int i = 0; i < NUM_CTRL; i++) begin
                if (ctrl_hit[i]) rd_d.data = rd_d.data | ctrl_q[i];
            end
            for (int j = 0; j < NUM_STAT; j++) begin
                if (stat_hit[j]) rd_d.data = rd_d.data | stat_i[j];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rdata_o = rd_q.data;
    assign ctrl_o  = ctrl_q;

    // R2
    decode_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctrl_hit, stat_hit}));

    // R8
    gate_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_set |=> ctrl_o[0][GATE_BIT]);

    // R6
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rdata_o));

    // R7
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && ctrl_hit == '0 && stat_hit == '0) |=> (rdata_o == '0));

    // R7
    stat_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && stat_hit != '0 && !gate_set) |=> (ctrl_o == $past(ctrl_o)));

endmodule

// File: tb/test_sct_reg_bank.sv
module test_sct_reg_bank;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 8;
    localparam int NUM_CTRL   = 4;
    localparam int NUM_STAT   = 2;
    localparam int RST_CYCLES = 4;

    logic                           clk = 1'b0;
    logic                           rst_n;
    logic [ADDR_W-1:0]              addr;
    logic                           wr_en;
    logic [31:0]                    wdata;
    logic                           rd_en;
    logic [31:0]                    rdata;
    logic [NUM_CTRL-1:0][31:0]      ctrl_o;
    logic [NUM_STAT-1:0][31:0]      stat_i;
    logic                           core_done;

    int          checks   = 0;
    int          failures = 0;
    bit          ended    = 1'b0;
    logic [31:0] exp_ctrl [NUM_CTRL];

    sct_reg_bank #(
        .ADDR_W     (ADDR_W),
        .NUM_CTRL   (NUM_CTRL),
        .NUM_STAT   (NUM_STAT),
        .RST_CYCLES (RST_CYCLES)
    ) i_sct_reg_bank (
        .clk             (clk),
        .rst_n           (rst_n),
        .addr_i          (addr),
        .wr_en_i         (wr_en),
        .wdata_i         (wdata),
        .rd_en_i         (rd_en),
        .rdata_o         (rdata),
        .ctrl_o          (ctrl_o),
        .stat_i          (stat_i),
        .core_rst_done_i (core_done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check32(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%08h expected=%08h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // called on a falling edge; returns on the falling edge after the capture edge
    task automatic bus_write(logic [ADDR_W-1:0] a, logic [31:0] d);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(logic [ADDR_W-1:0] a, output logic [31:0] v);
        addr  = a;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v     = rdata;
    endtask

    task automatic check_all_ctrl(string tag);
        for (int i = 0; i < NUM_CTRL; i++) begin
            check32(tag, $sformatf("ctrl%0d", i), ctrl_o[i], exp_ctrl[i]);
        end
    endtask

    function automatic logic [31:0] model_op(logic [1:0] kind, logic [31:0] cur, logic [31:0] wd);
        case (kind)
            2'b00:   return wd;
            2'b01:   return cur | wd;
            2'b10:   return cur & ~wd;
            default: return cur ^ wd;
        endcase
    endfunction

    function automatic string op_tag(logic [1:0] kind);
        case (kind)
            2'b00:   return "R2";
            2'b01:   return "R3";
            2'b10:   return "R4";
            default: return "R5";
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic [31:0] held;
        void'($urandom(32'd20240611));
        rst_n     = 1'b0;
        addr      = '0;
        wdata     = '0;
        wr_en     = 1'b0;
        rd_en     = 1'b0;
        core_done = 1'b1;
        stat_i[0] = 32'h1357_9BDF;
        stat_i[1] = 32'h2468_ACE0;
        for (int i = 0; i < NUM_CTRL; i++) exp_ctrl[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check_all_ctrl("R1");
        check32("R1", "rdata", rdata, 32'h0);

        // R2..R5 directed on slot 1
        bus_write(8'h10, 32'hA5A5_0F0F);
        check32("R2", "plain write", ctrl_o[1], 32'hA5A5_0F0F);
        bus_write(8'h14, 32'h0000_F000);
        check32("R3", "set alias", ctrl_o[1], 32'hA5A5_FF0F);
        bus_write(8'h18, 32'hA000_000F);
        check32("R4", "clear alias", ctrl_o[1], 32'h05A5_FF00);
        bus_write(8'h1C, 32'hFFFF_0000);
        check32("R5", "toggle alias", ctrl_o[1], 32'hFA5A_FF00);
        bus_write(8'h13, 32'h1234_5678);
        check32("R2", "low address bits ignored", ctrl_o[1], 32'h1234_5678);
        exp_ctrl[1] = 32'h1234_5678;
        check_all_ctrl("R12");

        // R6 reads at alias addresses
        bus_read(8'h1C, v);
        check32("R6", "read at toggle alias", v, 32'h1234_5678);
        bus_read(8'h36, v);
        check32("R6", "read slot3", v, 32'h0);

        // R6 read and write in the same cycle
        addr  = 8'h20;
        wdata = 32'hDEAD_BEEF;
        wr_en = 1'b1;
        rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        rd_en = 1'b0;
        check32("R6", "read beside write sees old value", rdata, 32'h0);
        exp_ctrl[2] = 32'hDEAD_BEEF;
        check32("R6", "write beside read lands", ctrl_o[2], 32'hDEAD_BEEF);
        held = rdata;
        addr = 8'h10;
        repeat (2) @(negedge clk);
        check32("R6", "rdata holds without strobe", rdata, held);

        // R7 status and unmapped slots
        bus_read(8'h40, v);
        check32("R7", "status 0", v, 32'h1357_9BDF);
        bus_read(8'h58, v);
        check32("R7", "status 1 via alias", v, 32'h2468_ACE0);
        bus_write(8'h44, 32'hFFFF_FFFF);
        check_all_ctrl("R7");
        bus_write(8'h5C, 32'hFFFF_FFFF);
        check_all_ctrl("R7");
        bus_read(8'h40, v);
        check32("R7", "status unchanged after write", v, 32'h1357_9BDF);
        bus_read(8'h70, v);
        check32("R7", "unmapped read", v, 32'h0);
        bus_write(8'h60, 32'hFFFF_FFFF);
        check_all_ctrl("R7");

        // random phase, soft reset bit kept clear
        for (int n = 0; n < 400; n++) begin
            logic [3:0]  slot;
            logic [1:0]  kind;
            logic [1:0]  lsb;
            logic [31:0] d;
            slot = 4'($urandom_range(7, 0));
            kind = 2'($urandom_range(3, 0));
            lsb  = 2'($urandom_range(3, 0));
            d    = $urandom();
            if (slot == 4'd0) d[31] = 1'b0;
            if (n % 97 == 0) stat_i[n % 2] = $urandom();
            if ($urandom_range(1, 0) == 0) begin
                bus_write({slot, kind, lsb}, d);
                if (slot < 4'(NUM_CTRL)) begin
                    exp_ctrl[slot] = model_op(kind, exp_ctrl[slot], d);
                    check_all_ctrl(op_tag(kind));
                end else begin
                    check_all_ctrl("R7");
                end
            end else begin
                bus_read({slot, kind, lsb}, v);
                if (slot < 4'(NUM_CTRL))
                    check32("R6", "random read ctrl", v, exp_ctrl[slot]);
                else if (slot < 4'(NUM_CTRL + NUM_STAT))
                    check32("R7", "random read status", v, stat_i[slot - 4'(NUM_CTRL)]);
                else
                    check32("R7", "random read unmapped", v, 32'h0);
            end
        end

        // R8 soft reset handshake timing
        bus_write(8'h00, 32'h0000_1234);
        exp_ctrl[0] = 32'h0000_1234;
        bus_write(8'h04, 32'h8000_0000);
        check32("R8", "gate low right after request", ctrl_o[0], 32'h8000_1234);
        repeat (RST_CYCLES - 1) @(negedge clk);
        check32("R8", "gate low one edge before", ctrl_o[0], 32'h8000_1234);
        @(negedge clk);
        check32("R8", "gate set after count", ctrl_o[0], 32'hC000_1234);
        exp_ctrl[0] = 32'hC000_1234;
        check_all_ctrl("R8");

        // R10 clear soft reset, gate stays
        bus_write(8'h08, 32'h8000_0000);
        bus_read(8'h00, v);
        check32("R10", "srst reads 0, gate kept", v, 32'h4000_1234);
        repeat (5) @(negedge clk);
        check32("R10", "gate still set", ctrl_o[0], 32'h4000_1234);
        bus_write(8'h08, 32'h4000_0000);
        check32("R10", "gate cleared by software", ctrl_o[0], 32'h0000_1234);

        // R9 core not done yet
        core_done = 1'b0;
        bus_write(8'h04, 32'h8000_0000);
        repeat (RST_CYCLES + 4) @(negedge clk);
        check32("R9", "gate waits for core", ctrl_o[0], 32'h8000_1234);
        core_done = 1'b1;
        @(negedge clk);
        check32("R9", "gate set once core done", ctrl_o[0], 32'hC000_1234);
        bus_write(8'h08, 32'hC000_0000);
        check32("R10", "both bits cleared", ctrl_o[0], 32'h0000_1234);

        // R11 completion edge meets a replacing write
        bus_write(8'h04, 32'h8000_0000);
        repeat (RST_CYCLES - 1) @(negedge clk);
        bus_write(8'h00, 32'h8000_0055);
        check32("R11", "plain write on completion edge", ctrl_o[0], 32'hC000_0055);

        // R11 completion edge meets a clear of the gate bit
        bus_write(8'h08, 32'hC000_0000);
        check32("R10", "bits cleared before second collision", ctrl_o[0], 32'h0000_0055);
        bus_write(8'h04, 32'h8000_0000);
        repeat (RST_CYCLES - 1) @(negedge clk);
        bus_write(8'h08, 32'h4000_0000);
        check32("R11", "gate clear on completion edge", ctrl_o[0], 32'hC000_0055);
        exp_ctrl[0] = 32'hC000_0055;

        // R12 output matches bus view
        for (int i = 0; i < NUM_CTRL; i++) begin
            bus_read(ADDR_W'(i * 16), v);
            check32("R12", "output equals read", ctrl_o[i], v);
        end
        check_all_ctrl("R12");

        finish_run();
    end

endmodule